// File: doc/BRIEF.md
# Pipelined Microprogram Sequencer

This block steps through a microprogram held in a control store outside the block. The store is read combinationally: the block drives the address, and the store returns the word at that address in the same cycle. A word register sits after the store. On every rising clock edge it takes the word at the current address, and the address register moves on. The next word is therefore already being read while the registered word executes, and straight-line code runs at one word per cycle.

Every word carries four things:

- a control field, driven straight out of the word register so that the outputs are glitch-free;
- a target address;
- a condition selector with a polarity bit;
- a two-bit mode.

The branch decision is made from the registered word. By the time a branch is taken, the sequential word behind it has already been fetched. That word is discarded: an all-zero no-operation enters the word register in its place, and the address register loads the target. A taken branch therefore spends two cycles between the branch word and the target word. External conditions pass through a synchronizer before the selector sees them.

Top module: `useq_pipe`

## Requirements
- R1: While rst_n is low, and immediately after it falls (asynchronously), ctrl_out is all zero and cs_addr is 0.
- R2: Word fields, from the least significant bit: control field [CTRL_W-1:0], target address (ADDR_W bits), condition selector (SEL_W = clog2(COND_N+2) bits), polarity bit, and mode in the two top bits (0 sequential, 1 branch, 2 wait, 3 reserved). A sequential word lets cs_addr advance by one per cycle, and the word presented at cs_addr appears on ctrl_out after the next rising edge.
- R3: When a branch word's condition is true, after the next edge ctrl_out is all zero and cs_addr equals the target. After the edge that follows, ctrl_out shows the target word's control field. This holds for a branch to its own address.
- R4: When a branch word's condition is false, the prefetched next word executes in the following cycle with no bubble.
- R5: Selector value 0 is always true. Selector value k, for k from 1 to COND_N, is synchronized condition k-1. Any larger value is false. A polarity bit of 1 inverts the result.
- R6: A wait word whose condition is false holds ctrl_out and cs_addr unchanged. Once the condition is true, execution proceeds sequentially.
- R7: A change on cond_async reaches the decision after SYNC_STAGES rising edges. With a 2-stage synchronizer, a wait is released on the third edge after its condition input rises.
- R8: Mode 3 behaves as a sequential word.
- R9: cs_addr wraps from 2^ADDR_W-1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single-phase clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cond_async | input | COND_N | Unsynchronized condition inputs |
| cs_addr | output | ADDR_W | Control store read address (prefetch pointer) |
| cs_word | input | WORD_W | Word read combinationally from the control store |
| ctrl_out | output | CTRL_W | Control field of the executing word |

## Verification
The bench builds the block with ADDR_W=4, CTRL_W=8, COND_N=3 and SYNC_STAGES=2. The 16-word address space lets a short program run off the top and wrap back to address 0. Three conditions under a 3-bit selector leave the values 4 to 7 free, so the out-of-range selector can be exercised. Two synchronizer stages make the wait-release edge an exact, countable point in time. One looping program takes branches that are taken, not taken, and inverted, meets a reserved mode, and wraps the address. A second program covers the wait stall, its release timing, a branch to its own address, and a reset asserted in the middle of a run.

// File: rtl/useq_pkg.sv
package useq_pkg;

  typedef enum logic [1:0] {
    MODE_SEQ    = 2'd0,
    MODE_BRANCH = 2'd1,
    MODE_WAIT   = 2'd2,
    MODE_RSVD   = 2'd3
  } useq_mode_e;

endpackage

// File: rtl/useq_cond_sync.sv
module useq_cond_sync #(
  parameter int COND_N = 4,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [COND_N-1:0] cond_async,
  output logic [COND_N-1:0] cond_sync
);

  logic [COND_N-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= cond_async;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[i] <= '0;
      else        stg[i] <= stg[i-1];
    end

    // R7: each stage adds exactly one edge of delay
    assert_sync_chain_R7: assert property (@(posedge clk) disable iff (!rst_n)
      stg[i] == $past(stg[i-1]));
  end

  assign cond_sync = stg[STAGES-1];

endmodule

// File: rtl/useq_cond_eval.sv
module useq_cond_eval #(
  parameter int COND_N = 4,
  parameter int SEL_W  = 3
) (
  input  logic [COND_N-1:0] cond,
  input  logic [SEL_W-1:0]  sel,
  input  logic              inv,
  output logic              hit
);

  // selector 0 is constant true, 1..COND_N pick a condition, the rest are false
  function automatic logic pick_cond(input logic [COND_N-1:0] c,
                                     input logic [SEL_W-1:0] s);
    logic r;
    r = (s == '0);
    for (int i = 0; i < COND_N; i++) begin
      if (s == SEL_W'(i + 1)) r = c[i];
    end
    return r;
  endfunction

  assign hit = pick_cond(cond, sel) ^ inv;

endmodule

// File: rtl/useq_next_ctl.sv
module useq_next_ctl
  import useq_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  useq_mode_e        mode,
  input  logic              hit,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [ADDR_W-1:0] target,
  output logic              taken,
  output logic              stall,
  output logic              advance,
  output logic [ADDR_W-1:0] next_addr
);

  function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  always_comb begin
    taken   = (mode == MODE_BRANCH) && hit;
    stall   = (mode == MODE_WAIT) && !hit;
    advance = !taken && !stall;
    if (taken)      next_addr = target;
    else if (stall) next_addr = cur_addr;
    else            next_addr = step_addr(cur_addr);
  end

endmodule

// File: rtl/useq_pipe.sv
module useq_pipe
  import useq_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int CTRL_W      = 8,
  parameter int COND_N      = 4,
  parameter int SYNC_STAGES = 2,
  localparam int SEL_W      = $clog2(COND_N + 2),
  localparam int WORD_W     = CTRL_W + ADDR_W + SEL_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [COND_N-1:0] cond_async,
  output logic [ADDR_W-1:0] cs_addr,
  input  logic [WORD_W-1:0] cs_word,
  output logic [CTRL_W-1:0] ctrl_out
);

  localparam int TGT_LO  = CTRL_W;
  localparam int SEL_LO  = TGT_LO + ADDR_W;
  localparam int INV_BIT = SEL_LO + SEL_W;
  localparam int MODE_LO = INV_BIT + 1;

  logic [WORD_W-1:0] ir_q;
  logic [ADDR_W-1:0] csar_q;

  logic [COND_N-1:0] cond_s;
  logic              hit;
  logic              taken, stall, advance;
  logic [ADDR_W-1:0] next_addr;
  useq_mode_e        mode_w;
  logic [ADDR_W-1:0] target_w;

  assign mode_w   = useq_mode_e'(ir_q[MODE_LO +: 2]);
  assign target_w = ir_q[TGT_LO +: ADDR_W];

  useq_cond_sync #(.COND_N(COND_N), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .cond_async(cond_async), .cond_sync(cond_s)
  );

  useq_cond_eval #(.COND_N(COND_N), .SEL_W(SEL_W)) u_eval (
    .cond(cond_s), .sel(ir_q[SEL_LO +: SEL_W]), .inv(ir_q[INV_BIT]), .hit(hit)
  );

  useq_next_ctl #(.ADDR_W(ADDR_W)) u_next (
    .mode(mode_w), .hit(hit), .cur_addr(csar_q), .target(target_w),
    .taken(taken), .stall(stall), .advance(advance), .next_addr(next_addr)
  );

  // fetch register and word register, both on the single rising edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csar_q <= '0;
      ir_q   <= '0;
    end else begin
      csar_q <= next_addr;
      if (taken)      ir_q <= '0;
      else if (!stall) ir_q <= cs_word;
    end
  end

  assign cs_addr  = csar_q;
  assign ctrl_out = ir_q[CTRL_W-1:0];

  // R3: the wrongly fetched word is replaced by a no-operation
  assert_squash_nop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    taken |=> (ctrl_out == '0));

  // R3: the fetch pointer lands on the branch target
  assert_target_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    taken |=> (cs_addr == $past(target_w)));

  // R4: a branch that falls through executes the prefetched word with no bubble
  assert_no_bubble_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_w == MODE_BRANCH && !hit) |=> (ctrl_out == $past(cs_word[CTRL_W-1:0])));

  // R6: a pending wait freezes both registers
  assert_wait_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> ($stable(ctrl_out) && $stable(cs_addr)));

  // R2: sequential flow moves the pointer by exactly one
  assert_seq_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> ((cs_addr - $past(cs_addr)) == ADDR_W'(1)));

endmodule

// File: tb/useq_pipe_test.sv
module useq_pipe_test;

  localparam int AW = 4;
  localparam int CW = 8;
  localparam int CN = 3;
  localparam int WW = CW + AW + 3 + 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CN-1:0] cond_async = '0;
  logic [AW-1:0] cs_addr;
  logic [WW-1:0] cs_word;
  logic [CW-1:0] ctrl_out;
  logic [WW-1:0] mem [16];

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  always #4 clk = ~clk;

  assign cs_word = mem[cs_addr];

  useq_pipe #(.ADDR_W(AW), .CTRL_W(CW), .COND_N(CN), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .cond_async(cond_async),
    .cs_addr(cs_addr), .cs_word(cs_word), .ctrl_out(ctrl_out)
  );

  function automatic logic [WW-1:0] mk(input logic [1:0] m, input logic inv,
                                       input logic [2:0] sel, input logic [3:0] t,
                                       input logic [7:0] c);
    return {m, inv, sel, t, c};
  endfunction

  // expected {ctrl_out, cs_addr} after each edge of the first program
  localparam logic [11:0] EXP [16] = '{
    12'h101, 12'h112, 12'h005, 12'h156, 12'h167, 12'h178, 12'h00A, 12'h1AB,
    12'h1BC, 12'h00E, 12'h1EF, 12'h1F0, 12'h101, 12'h112, 12'h005, 12'h156
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic fill_default();
    for (int i = 0; i < 16; i++) mem[i] = mk(2'd0, 1'b0, 3'd0, 4'd0, 8'h10 + 8'(i));
  endtask

  initial begin
    fill_default();
    mem[1]  = mk(2'd1, 1'b0, 3'd0, 4'd5,  8'h11); // always taken
    mem[6]  = mk(2'd1, 1'b0, 3'd1, 4'd9,  8'h16); // cond0 low: falls through
    mem[7]  = mk(2'd1, 1'b1, 3'd1, 4'd10, 8'h17); // inverted cond0: taken
    mem[10] = mk(2'd1, 1'b0, 3'd7, 4'd0,  8'h1A); // out-of-range selector
    mem[11] = mk(2'd1, 1'b0, 3'd2, 4'd14, 8'h1B); // cond1 high: taken
    mem[15] = mk(2'd3, 1'b0, 3'd0, 4'd0,  8'h1F); // reserved mode
    cond_async = 3'b010;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset ctrl", ctrl_out, 8'h00);
    chk("R1 reset addr", 8'(cs_addr), 8'h00);
    rst_n = 1'b1;
    for (int k = 0; k < 16; k++) begin
      step();
      chk($sformatf("R2/R3/R4/R5/R8/R9 ctrl step %0d", k), ctrl_out, EXP[k][11:4]);
      chk($sformatf("R2/R3/R4/R5/R8/R9 addr step %0d", k), 8'(cs_addr), 8'(EXP[k][3:0]));
    end

    // reset in the middle of a run takes effect without a clock edge
    rst_n = 1'b0;
    #1;
    chk("R1 async ctrl", ctrl_out, 8'h00);
    chk("R1 async addr", 8'(cs_addr), 8'h00);
    fill_default();
    mem[0] = mk(2'd0, 1'b0, 3'd0, 4'd0, 8'h30);
    mem[1] = mk(2'd2, 1'b0, 3'd3, 4'd0, 8'h31); // wait on cond2
    mem[2] = mk(2'd0, 1'b0, 3'd0, 4'd0, 8'h32);
    mem[3] = mk(2'd1, 1'b0, 3'd0, 4'd3, 8'h33); // branch to itself
    cond_async = 3'b000;
    @(negedge clk);
    rst_n = 1'b1;
    step();
    chk("R2 first word", ctrl_out, 8'h30);
    step();
    chk("R6 wait entered", ctrl_out, 8'h31);
    for (int k = 0; k < 5; k++) begin
      step();
      chk("R6 wait ctrl held", ctrl_out, 8'h31);
      chk("R6 wait addr held", 8'(cs_addr), 8'h02);
    end
    cond_async = 3'b100;
    step();
    chk("R7 edge1 still waiting", ctrl_out, 8'h31);
    step();
    chk("R7 edge2 still waiting", ctrl_out, 8'h31);
    step();
    chk("R7 edge3 released", ctrl_out, 8'h32);
    chk("R6 addr after release", 8'(cs_addr), 8'h03);
    step();
    chk("R3 self branch word", ctrl_out, 8'h33);
    step();
    chk("R3 self branch nop", ctrl_out, 8'h00);
    chk("R3 self branch addr", 8'(cs_addr), 8'h03);
    step();
    chk("R3 self branch again", ctrl_out, 8'h33);
    step();
    chk("R3 second nop", ctrl_out, 8'h00);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule